// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block is the part of a CPU core that takes an accepted interrupt to the first fetch of its handler. It checks for requests only at points where entry is allowed. These are the cycle in which the current instruction retires, and any cycle of an instruction marked as suspendable, such as a block move, a string store or a multiply-accumulate loop. A request accepted in one cycle starts the sequence in the next cycle. The sequence then runs a fixed 20-cycle script on a byte-wide memory bus:

- an acknowledge read that returns the interrupt number and the request level;
- a save of the flag word into a hidden holding register, followed by the flag update;
- four byte pushes onto the stack;
- an update of the priority level;
- three byte reads that form the handler address.

The block talks to the register file through value and write-enable pairs for the stack pointer, program counter, flag word and priority level. The register file applies each write at the clock edge that ends the cycle in which the write-enable is high. Software interrupts use the same script. They take their number from a side input instead of the acknowledge read, and they may keep the stack-select flag. The handler address is taken from a vector table: entry n starts at `VEC_BASE + 4*n`.

Top module: `irq_entry_seq`

## Requirements
- R1: A hardware request (`req_i`) is accepted only when all three of these hold: `insn_end_i` or `long_insn_i` is high, flag bit 6 (interrupt enable) of `flg_i` is 1, and `req_lvl_i` is greater than `ipl_i`. A software request (`swi_req_i`) is accepted at the same points whatever the enable bit, and it wins over a hardware request. `busy_o` rises in the cycle after acceptance.
- R2: `suspend_o` pulses in the accepting cycle when `long_insn_i` is high and `insn_end_i` is low, and stays low otherwise.
- R3: In step 0 of a hardware entry, the bus reads address 0. Bits [7:5] of the returned byte are the request level and bits [4:0] are the interrupt number. A software entry performs no bus cycle in step 0.
- R4: In step 1, `flg_we_o` is high and `flg_o` equals `flg_i` with bit 6 (interrupt enable), bit 1 (single-step enable) and bit 7 (stack select) cleared. The unmodified word is kept in the holding register.
- R5: A software entry with number 32 to 63 leaves bit 7 of the flag word unchanged. A software entry with a lower number clears it.
- R6: Let SP be `sp_i` sampled in step 2 and PC be `pc_i` in the accepting cycle. The block writes SP-2 = held[7:0] in step 3, SP-1 = {held[15:12], PC[19:16]} in step 5, SP-4 = PC[7:0] in step 7, and SP-3 = PC[15:8] in step 9. Each address is zero-extended to 20 bits.
- R7: In step 10 of a hardware entry, `ipl_we_o` is high and `ipl_o` equals the level from the acknowledge byte. A software entry never writes the priority level.
- R8: The bus reads VEC, VEC+1 and VEC+2 in steps 11, 13 and 15, where VEC = `VEC_BASE` + 4 times the interrupt number. In step 19, `pc_we_o` is high and `pc_o` is {byte2[3:0], byte1, byte0}.
- R9: Step 19 is the last step. In it, `done_o` is high, `sp_we_o` is high with `sp_o` = SP-4, and `busy_o` has been high for exactly 20 cycles.
- R10: In every step not named above, `bus_rd_o` and `bus_wr_o` are low. They are never high together, and both stay low while the block is idle.
- R11: Requests of either kind that arrive while the sequence runs have no effect. After step 19 the block returns to idle.
- R12: While reset is held, and after it is released, `busy_o`, `done_o`, `bus_rd_o` and `bus_wr_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_end_i | input | 1 | Current instruction retires this cycle |
| long_insn_i | input | 1 | Current instruction may be suspended |
| req_i | input | 1 | Hardware interrupt pending |
| req_lvl_i | input | 3 | Level of the pending hardware request |
| swi_req_i | input | 1 | Software interrupt instruction executing |
| swi_num_i | input | 6 | Software interrupt number |
| bus_addr_o | output | 20 | Bus address |
| bus_rdata_i | input | 8 | Bus read data |
| bus_wdata_o | output | 8 | Bus write data |
| bus_rd_o | output | 1 | Bus read strobe |
| bus_wr_o | output | 1 | Bus write strobe |
| sp_i | input | 16 | Current stack pointer |
| sp_o | output | 16 | New stack pointer |
| sp_we_o | output | 1 | Stack pointer write |
| pc_i | input | 20 | Resume address |
| pc_o | output | 20 | Handler address |
| pc_we_o | output | 1 | Program counter write |
| flg_i | input | 16 | Current flag word |
| flg_o | output | 16 | Updated flag word |
| flg_we_o | output | 1 | Flag word write |
| ipl_i | input | 3 | Current priority level |
| ipl_o | output | 3 | New priority level |
| ipl_we_o | output | 1 | Priority level write |
| busy_o | output | 1 | Sequence running |
| suspend_o | output | 1 | Suspendable instruction abandoned |
| done_o | output | 1 | Final step of the sequence |

## Verification
The bench goes after the stack order, because a design that pushes in address order would store the held flags at SP-4 and SP-3 and corrupt the saved frame. It runs a software entry with number 40, where a design that clears the stack-select bit regardless would switch stacks under a trap, and one with number 10, where that bit must still be cleared. Requests are blocked in turn by the enable bit, by an equal level, and by the lack of an entry point, and a design that ignores any one of these starts a sequence that the scoreboard flags as unexpected bus cycles. A software request held during a running sequence, and a vector whose top byte carries high bits, catch a design that restarts mid-sequence or loads all 24 vector bits.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

  localparam int ADDR_W    = 20;
  localparam int BYTE_W    = 8;
  localparam int SP_W      = 16;
  localparam int FLG_W     = 16;
  localparam int LVL_W     = 3;
  localparam int NUM_W     = 6;
  localparam int HWNUM_W   = 5;
  localparam int SEQ_LEN   = 20;
  localparam int STEP_W    = $clog2(SEQ_LEN);
  localparam int VEC_BYTES = 3;
  localparam int PUSH_BYTES = 4;
  localparam int VEC_STRIDE_SH = 2;

  // flag word bit positions
  localparam int FLG_D = 1;
  localparam int FLG_I = 6;
  localparam int FLG_U = 7;

  localparam logic [STEP_W-1:0] STEP_FLG  = STEP_W'(1);
  localparam logic [STEP_W-1:0] STEP_SP   = STEP_W'(2);
  localparam logic [STEP_W-1:0] STEP_IPL  = STEP_W'(10);
  localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(SEQ_LEN - 1);

  typedef enum logic {ST_IDLE, ST_RUN} seq_state_e;

  typedef enum logic [1:0] {OP_NONE, OP_ACK, OP_PUSH, OP_VEC} bus_op_e;

  typedef struct packed {
    bus_op_e    op;
    logic [1:0] idx;
  } step_op_t;

  // bus activity scheduled for each step of the script
  function automatic step_op_t decode_step(input logic [STEP_W-1:0] s);
    step_op_t r;
    r.op  = OP_NONE;
    r.idx = 2'd0;
    case (s)
      STEP_W'(0):  r.op = OP_ACK;
      STEP_W'(3):  begin r.op = OP_PUSH; r.idx = 2'd0; end
      STEP_W'(5):  begin r.op = OP_PUSH; r.idx = 2'd1; end
      STEP_W'(7):  begin r.op = OP_PUSH; r.idx = 2'd2; end
      STEP_W'(9):  begin r.op = OP_PUSH; r.idx = 2'd3; end
      STEP_W'(11): begin r.op = OP_VEC;  r.idx = 2'd0; end
      STEP_W'(13): begin r.op = OP_VEC;  r.idx = 2'd1; end
      STEP_W'(15): begin r.op = OP_VEC;  r.idx = 2'd2; end
      default: ;
    endcase
    return r;
  endfunction

  // distance below the stack pointer for each push, in issue order
  function automatic logic [SP_W-1:0] push_offset(input logic [1:0] idx);
    case (idx)
      2'd0:    return SP_W'(2);
      2'd1:    return SP_W'(1);
      2'd2:    return SP_W'(4);
      default: return SP_W'(3);
    endcase
  endfunction

endpackage

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
  import irq_entry_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              insn_end_i,
  input  logic              long_insn_i,
  input  logic              req_i,
  input  logic [LVL_W-1:0]  req_lvl_i,
  input  logic              swi_req_i,
  input  logic              flg_ie_i,
  input  logic [LVL_W-1:0]  ipl_i,
  output logic              run_o,
  output logic [STEP_W-1:0] step_o,
  output logic              accept_o,
  output logic              from_swi_o,
  output logic              suspend_o,
  output logic              done_o
);

  seq_state_e        state_q, state_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic              step_en;
  logic              swi_q;
  logic              boundary, hw_ok, accept, done;

  always_comb begin
    boundary = insn_end_i | long_insn_i;
    hw_ok    = req_i & flg_ie_i & (req_lvl_i > ipl_i);
    accept   = (state_q == ST_IDLE) & boundary & (swi_req_i | hw_ok);
    done     = (state_q == ST_RUN) & (step_q == STEP_LAST);
  end

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (accept) state_d = ST_RUN;
      ST_RUN:  if (done)   state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
    step_en = accept | ((state_q == ST_RUN) & ~done);
    step_d  = accept ? '0 : step_q + STEP_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      swi_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (step_en) step_q <= step_d;
      if (accept)  swi_q  <= swi_req_i;
    end
  end

  assign run_o      = (state_q == ST_RUN);
  assign step_o     = step_q;
  assign accept_o   = accept;
  assign from_swi_o = swi_q;
  assign suspend_o  = accept & long_insn_i & ~insn_end_i;
  assign done_o     = done;

endmodule

// File: rtl/irq_entry_data.sv
module irq_entry_data
  import irq_entry_pkg::*;
#(
  parameter logic [ADDR_W-1:0] VEC_BASE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept_i,
  input  logic              run_i,
  input  logic [STEP_W-1:0] step_i,
  input  logic              from_swi_i,
  input  logic              done_i,
  input  logic [NUM_W-1:0]  swi_num_i,
  input  logic [BYTE_W-1:0] bus_rdata_i,
  input  logic [FLG_W-1:0]  flg_i,
  input  logic [SP_W-1:0]   sp_i,
  input  logic [ADDR_W-1:0] pc_i,
  output logic [FLG_W-1:0]  held_o,
  output logic [SP_W-1:0]   sp_base_o,
  output logic [ADDR_W-1:0] pc_save_o,
  output logic [ADDR_W-1:0] vec_addr_o,
  output logic [FLG_W-1:0]  flg_o,
  output logic              flg_we_o,
  output logic [LVL_W-1:0]  ipl_o,
  output logic              ipl_we_o,
  output logic [SP_W-1:0]   sp_o,
  output logic              sp_we_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic              pc_we_o
);

  localparam int VEC_W = VEC_BYTES * BYTE_W;

  step_op_t          cur;
  logic              ack_en, held_en, sp_en;
  logic [NUM_W-1:0]  num_q, num_d;
  logic              num_en;
  logic [LVL_W-1:0]  lvl_q;
  logic [FLG_W-1:0]  held_q;
  logic [SP_W-1:0]   sp_q;
  logic [ADDR_W-1:0] pc_q;
  logic [VEC_W-1:0]  vec_flat;
  logic              keep_u;

  always_comb begin
    cur     = run_i ? decode_step(step_i) : '{op: OP_NONE, idx: 2'd0};
    ack_en  = (cur.op == OP_ACK) & ~from_swi_i;
    held_en = run_i & (step_i == STEP_FLG);
    sp_en   = run_i & (step_i == STEP_SP);
    num_en  = accept_i | ack_en;
    num_d   = accept_i ? swi_num_i : NUM_W'(bus_rdata_i[HWNUM_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      num_q  <= '0;
      lvl_q  <= '0;
      held_q <= '0;
      sp_q   <= '0;
      pc_q   <= '0;
    end else begin
      if (num_en)   num_q  <= num_d;
      if (ack_en)   lvl_q  <= bus_rdata_i[BYTE_W-1 -: LVL_W];
      if (held_en)  held_q <= flg_i;
      if (sp_en)    sp_q   <= sp_i;
      if (accept_i) pc_q   <= pc_i;
    end
  end

  // one capture register per vector byte
  for (genvar g = 0; g < VEC_BYTES; g++) begin : g_vbyte
    logic [BYTE_W-1:0] b_q;
    logic              b_en;
    assign b_en = (cur.op == OP_VEC) & (cur.idx == 2'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    b_q <= '0;
      else if (b_en) b_q <= bus_rdata_i;
    end
    assign vec_flat[g*BYTE_W +: BYTE_W] = b_q;
  end

  always_comb begin
    keep_u = from_swi_i & num_q[NUM_W-1];
    flg_o  = flg_i;
    flg_o[FLG_I] = 1'b0;
    flg_o[FLG_D] = 1'b0;
    if (!keep_u) flg_o[FLG_U] = 1'b0;
  end

  assign flg_we_o   = held_en;
  assign ipl_o      = lvl_q;
  assign ipl_we_o   = run_i & (step_i == STEP_IPL) & ~from_swi_i;
  assign sp_o       = sp_q - SP_W'(PUSH_BYTES);
  assign sp_we_o    = done_i;
  assign pc_o       = vec_flat[ADDR_W-1:0];
  assign pc_we_o    = done_i;
  assign held_o     = held_q;
  assign sp_base_o  = sp_q;
  assign pc_save_o  = pc_q;
  assign vec_addr_o = VEC_BASE + (ADDR_W'(num_q) << VEC_STRIDE_SH);

endmodule

// File: rtl/irq_entry_bus.sv
module irq_entry_bus
  import irq_entry_pkg::*;
(
  input  logic              run_i,
  input  logic [STEP_W-1:0] step_i,
  input  logic              from_swi_i,
  input  logic [FLG_W-1:0]  held_i,
  input  logic [SP_W-1:0]   sp_base_i,
  input  logic [ADDR_W-1:0] pc_save_i,
  input  logic [ADDR_W-1:0] vec_addr_i,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [BYTE_W-1:0] bus_wdata_o,
  output logic              bus_rd_o,
  output logic              bus_wr_o
);

  step_op_t          cur;
  logic [BYTE_W-1:0] push_byte;

  always_comb begin
    case (cur.idx)
      2'd0:    push_byte = held_i[BYTE_W-1:0];
      2'd1:    push_byte = {held_i[FLG_W-1 -: 4], pc_save_i[ADDR_W-1 -: 4]};
      2'd2:    push_byte = pc_save_i[BYTE_W-1:0];
      default: push_byte = pc_save_i[2*BYTE_W-1:BYTE_W];
    endcase
  end

  always_comb begin
    cur         = run_i ? decode_step(step_i) : '{op: OP_NONE, idx: 2'd0};
    bus_addr_o  = '0;
    bus_wdata_o = '0;
    bus_rd_o    = 1'b0;
    bus_wr_o    = 1'b0;
    case (cur.op)
      OP_ACK:  bus_rd_o = ~from_swi_i;
      OP_PUSH: begin
        bus_wr_o    = 1'b1;
        bus_addr_o  = ADDR_W'(sp_base_i - push_offset(cur.idx));
        bus_wdata_o = push_byte;
      end
      OP_VEC: begin
        bus_rd_o   = 1'b1;
        bus_addr_o = vec_addr_i + ADDR_W'(cur.idx);
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_entry_pkg::*;
#(
  parameter logic [ADDR_W-1:0] VEC_BASE = 20'hFFD00,
  parameter int                RST_SYNC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              insn_end_i,
  input  logic              long_insn_i,
  input  logic              req_i,
  input  logic [LVL_W-1:0]  req_lvl_i,
  input  logic              swi_req_i,
  input  logic [NUM_W-1:0]  swi_num_i,
  output logic [ADDR_W-1:0] bus_addr_o,
  input  logic [BYTE_W-1:0] bus_rdata_i,
  output logic [BYTE_W-1:0] bus_wdata_o,
  output logic              bus_rd_o,
  output logic              bus_wr_o,
  input  logic [SP_W-1:0]   sp_i,
  output logic [SP_W-1:0]   sp_o,
  output logic              sp_we_o,
  input  logic [ADDR_W-1:0] pc_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic              pc_we_o,
  input  logic [FLG_W-1:0]  flg_i,
  output logic [FLG_W-1:0]  flg_o,
  output logic              flg_we_o,
  input  logic [LVL_W-1:0]  ipl_i,
  output logic [LVL_W-1:0]  ipl_o,
  output logic              ipl_we_o,
  output logic              busy_o,
  output logic              suspend_o,
  output logic              done_o
);

  logic [RST_SYNC-1:0] rst_sync_q;
  logic                core_rst_n;
  logic                run, accept, from_swi, done;
  logic [STEP_W-1:0]   step;
  logic [FLG_W-1:0]    held;
  logic [SP_W-1:0]     sp_base;
  logic [ADDR_W-1:0]   pc_save, vec_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[RST_SYNC-2:0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[RST_SYNC-1];

  irq_entry_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .insn_end_i (insn_end_i),
    .long_insn_i(long_insn_i),
    .req_i      (req_i),
    .req_lvl_i  (req_lvl_i),
    .swi_req_i  (swi_req_i),
    .flg_ie_i   (flg_i[FLG_I]),
    .ipl_i      (ipl_i),
    .run_o      (run),
    .step_o     (step),
    .accept_o   (accept),
    .from_swi_o (from_swi),
    .suspend_o  (suspend_o),
    .done_o     (done)
  );

  irq_entry_data #(.VEC_BASE(VEC_BASE)) u_data (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .accept_i   (accept),
    .run_i      (run),
    .step_i     (step),
    .from_swi_i (from_swi),
    .done_i     (done),
    .swi_num_i  (swi_num_i),
    .bus_rdata_i(bus_rdata_i),
    .flg_i      (flg_i),
    .sp_i       (sp_i),
    .pc_i       (pc_i),
    .held_o     (held),
    .sp_base_o  (sp_base),
    .pc_save_o  (pc_save),
    .vec_addr_o (vec_addr),
    .flg_o      (flg_o),
    .flg_we_o   (flg_we_o),
    .ipl_o      (ipl_o),
    .ipl_we_o   (ipl_we_o),
    .sp_o       (sp_o),
    .sp_we_o    (sp_we_o),
    .pc_o       (pc_o),
    .pc_we_o    (pc_we_o)
  );

  irq_entry_bus u_bus (
    .run_i      (run),
    .step_i     (step),
    .from_swi_i (from_swi),
    .held_i     (held),
    .sp_base_i  (sp_base),
    .pc_save_i  (pc_save),
    .vec_addr_i (vec_addr),
    .bus_addr_o (bus_addr_o),
    .bus_wdata_o(bus_wdata_o),
    .bus_rd_o   (bus_rd_o),
    .bus_wr_o   (bus_wr_o)
  );

  assign busy_o = run;
  assign done_o = done;

endmodule

// File: rtl/irq_entry_chk.sv
module irq_entry_chk
  import irq_entry_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              insn_end_i,
  input logic              long_insn_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              suspend_o,
  input logic              bus_rd_o,
  input logic              bus_wr_o,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic              flg_we_o,
  input logic [FLG_W-1:0]  flg_o
);

  logic [STEP_W:0] busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      busy_cnt <= '0;
    else if (busy_o) busy_cnt <= busy_cnt + 1'b1;
    else             busy_cnt <= '0;
  end

  assert_rise_at_boundary_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(insn_end_i || long_insn_i));

  assert_suspend_starts_R2: assert property (@(posedge clk) disable iff (!rst_n)
    suspend_o |=> (busy_o && busy_cnt == '0));

  assert_ack_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_o && bus_addr_o == '0) |-> (busy_cnt == '0));

  assert_flag_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    flg_we_o |-> (!flg_o[FLG_I] && !flg_o[FLG_D] && busy_cnt == 1));

  assert_done_length_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (busy_o && busy_cnt == (STEP_W+1)'(SEQ_LEN - 1)));

  assert_rdwr_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd_o && bus_wr_o));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!bus_rd_o && !bus_wr_o));

  assert_end_only_by_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> $past(done_o));

endmodule

bind irq_entry_seq irq_entry_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .insn_end_i (insn_end_i),
  .long_insn_i(long_insn_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .suspend_o  (suspend_o),
  .bus_rd_o   (bus_rd_o),
  .bus_wr_o   (bus_wr_o),
  .bus_addr_o (bus_addr_o),
  .flg_we_o   (flg_we_o),
  .flg_o      (flg_o)
);

// File: tb/irq_entry_seq_tb.sv
`timescale 1ns/1ps
module irq_entry_seq_tb;

  localparam logic [19:0] VB = 20'hFFD00;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        insn_end, long_insn, req, swi_req;
  logic [2:0]  req_lvl;
  logic [5:0]  swi_num;
  logic [19:0] bus_addr, pc_o, rf_pc;
  logic [7:0]  bus_rdata, bus_wdata;
  logic        bus_rd, bus_wr;
  logic [15:0] sp_o, flg_o, rf_sp, rf_flg;
  logic [2:0]  ipl_o, rf_ipl;
  logic        sp_we, pc_we, flg_we, ipl_we, busy, suspend, done;

  irq_entry_seq #(.VEC_BASE(VB)) u_dut (
    .clk(clk), .rst_n(rst_n), .insn_end_i(insn_end), .long_insn_i(long_insn),
    .req_i(req), .req_lvl_i(req_lvl), .swi_req_i(swi_req), .swi_num_i(swi_num),
    .bus_addr_o(bus_addr), .bus_rdata_i(bus_rdata), .bus_wdata_o(bus_wdata),
    .bus_rd_o(bus_rd), .bus_wr_o(bus_wr),
    .sp_i(rf_sp), .sp_o(sp_o), .sp_we_o(sp_we),
    .pc_i(rf_pc), .pc_o(pc_o), .pc_we_o(pc_we),
    .flg_i(rf_flg), .flg_o(flg_o), .flg_we_o(flg_we),
    .ipl_i(rf_ipl), .ipl_o(ipl_o), .ipl_we_o(ipl_we),
    .busy_o(busy), .suspend_o(suspend), .done_o(done)
  );

  int n_chk = 0;
  int n_err = 0;

  task automatic chk(input bit ok, input string req_tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req_tag, act, exp);
    end
  endtask

  // register file model
  logic        rf_load = 1'b0;
  logic [15:0] nf_flg, nf_sp;
  logic [19:0] nf_pc;
  logic [2:0]  nf_ipl;
  always @(posedge clk) begin
    if (rf_load) begin
      rf_flg <= nf_flg; rf_sp <= nf_sp; rf_pc <= nf_pc; rf_ipl <= nf_ipl;
    end else begin
      if (flg_we) rf_flg <= flg_o;
      if (sp_we)  rf_sp  <= sp_o;
      if (pc_we)  rf_pc  <= pc_o;
      if (ipl_we) rf_ipl <= ipl_o;
    end
  end

  // memory model
  logic [7:0]  ack_byte;
  logic [19:0] vec_exp;
  logic [23:0] vec_bytes;
  always_comb begin
    if (bus_addr == 20'h0)               bus_rdata = ack_byte;
    else if (bus_addr == vec_exp)        bus_rdata = vec_bytes[7:0];
    else if (bus_addr == vec_exp + 20'd1) bus_rdata = vec_bytes[15:8];
    else if (bus_addr == vec_exp + 20'd2) bus_rdata = vec_bytes[23:16];
    else                                 bus_rdata = 8'h00;
  end

  // scoreboard
  typedef struct { logic wr; logic [19:0] addr; logic [7:0] data; } item_t;
  item_t sb_q[$];
  logic [15:0] exp_flg, exp_sp;
  logic [19:0] exp_pc;
  logic [2:0]  exp_ipl;
  int ipl_writes, busy_cnt;
  bit mon_en = 1'b0;

  task automatic push_item(input logic wr, input logic [19:0] a, input logic [7:0] d);
    item_t it;
    it.wr = wr; it.addr = a; it.data = d;
    sb_q.push_back(it);
  endtask

  always @(negedge clk) if (mon_en) begin
    if (busy) busy_cnt++;
    chk(!(bus_rd && bus_wr), "R10 rd/wr exclusive", {bus_rd, bus_wr}, 0);
    if (bus_rd || bus_wr) begin
      if (sb_q.size() == 0) chk(0, "R10 unexpected bus cycle", {bus_wr, bus_addr, bus_wdata}, 0);
      else begin
        item_t it;
        it = sb_q.pop_front();
        // R3 ack read, R6 push order, R8 vector reads
        chk(bus_wr == it.wr && bus_addr == it.addr && (!it.wr || bus_wdata == it.data),
            "R3/R6/R8 bus item", {bus_wr, bus_addr, bus_wdata}, {it.wr, it.addr, it.data});
      end
    end
    if (flg_we) chk(flg_o == exp_flg, "R4/R5 flag update", flg_o, exp_flg);
    if (ipl_we) begin
      ipl_writes++;
      chk(ipl_o == exp_ipl, "R7 priority level", ipl_o, exp_ipl);
    end
    if (pc_we) chk(pc_o == exp_pc, "R8 handler address", pc_o, exp_pc);
    if (sp_we) chk(sp_o == exp_sp, "R9 stack pointer", sp_o, exp_sp);
    if (done) begin
      chk(busy_cnt == 20, "R9 sequence length", busy_cnt, 20);
      busy_cnt = 0;
    end
  end

  task automatic load_rf(input logic [15:0] f, input logic [15:0] s, input logic [19:0] p, input logic [2:0] l);
    @(negedge clk);
    nf_flg = f; nf_sp = s; nf_pc = p; nf_ipl = l; rf_load = 1'b1;
    @(negedge clk);
    rf_load = 1'b0;
  endtask

  task automatic clear_inputs();
    insn_end = 1'b0; long_insn = 1'b0; req = 1'b0; swi_req = 1'b0;
    req_lvl = 3'd0; swi_num = 6'd0;
  endtask

  // full entry: expectations are queued, then the request is raised
  task automatic run_entry(input bit is_swi, input logic [5:0] num, input logic [2:0] lvl,
                           input logic [15:0] f, input logic [15:0] s, input logic [19:0] p,
                           input logic [2:0] ipl, input bit longi, input logic [23:0] vb,
                           input bit late_boundary, input bit poke);
    logic [5:0] eff_num;
    load_rf(f, s, p, ipl);
    eff_num   = is_swi ? num : {1'b0, num[4:0]};
    ack_byte  = {lvl, num[4:0]};
    vec_exp   = VB + {12'h0, eff_num, 2'b00};
    vec_bytes = vb;
    exp_flg   = f & ~16'h0042;
    if (!(is_swi && num >= 6'd32)) exp_flg = exp_flg & ~16'h0080;
    exp_ipl   = lvl;
    exp_pc    = {vb[19:16], vb[15:8], vb[7:0]};
    exp_sp    = s - 16'd4;
    ipl_writes = 0;
    busy_cnt   = 0;
    if (!is_swi) push_item(1'b0, 20'h0, 8'h00);
    push_item(1'b1, {4'h0, s - 16'd2}, f[7:0]);
    push_item(1'b1, {4'h0, s - 16'd1}, {f[15:12], p[19:16]});
    push_item(1'b1, {4'h0, s - 16'd4}, p[7:0]);
    push_item(1'b1, {4'h0, s - 16'd3}, p[15:8]);
    push_item(1'b0, vec_exp, 8'h00);
    push_item(1'b0, vec_exp + 20'd1, 8'h00);
    push_item(1'b0, vec_exp + 20'd2, 8'h00);
    @(negedge clk);
    if (is_swi) begin swi_req = 1'b1; swi_num = num; end
    else        begin req = 1'b1; req_lvl = lvl; end
    if (late_boundary) begin
      repeat (3) @(negedge clk);
      chk(busy == 1'b0, "R1 no entry between instructions", busy, 0);
    end
    insn_end = !longi; long_insn = longi;
    #5;
    chk(suspend == longi, "R2 suspend pulse", suspend, longi);
    @(negedge clk);
    chk(busy == 1'b1, "R1 busy the cycle after acceptance", busy, 1);
    clear_inputs();
    if (poke) begin
      repeat (4) @(negedge clk);
      swi_req = 1'b1; req = 1'b1; req_lvl = 3'd7; insn_end = 1'b1;
      repeat (3) @(negedge clk);
      clear_inputs();
    end
    for (int i = 0; i < 40 && !done; i++) @(negedge clk);
    @(negedge clk);
    chk(busy == 1'b0, "R11 idle after final step", busy, 0);
    chk(sb_q.size() == 0, "R6/R8 all bus cycles seen", sb_q.size(), 0);
    chk(ipl_writes == (is_swi ? 0 : 1), "R7 priority writes", ipl_writes, is_swi ? 0 : 1);
    repeat (2) @(negedge clk);
    chk(busy == 1'b0, "R11 no restart", busy, 0);
  endtask

  // request that must not be accepted
  task automatic blocked(input logic [15:0] f, input logic [2:0] ipl, input logic [2:0] lvl, input string tag);
    load_rf(f, 16'h0800, 20'h01234, ipl);
    @(negedge clk);
    req = 1'b1; req_lvl = lvl; insn_end = 1'b1;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, tag, busy, 0);
    clear_inputs();
    @(negedge clk);
  endtask

  initial begin
    clear_inputs();
    ack_byte = 8'h00; vec_exp = 20'h0; vec_bytes = 24'h0;
    exp_flg = 16'h0; exp_sp = 16'h0; exp_pc = 20'h0; exp_ipl = 3'h0;
    nf_flg = 16'h0; nf_sp = 16'h0; nf_pc = 20'h0; nf_ipl = 3'h0;
    ipl_writes = 0; busy_cnt = 0;
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && bus_rd == 0 && bus_wr == 0, "R12 outputs in reset",
        {busy, done, bus_rd, bus_wr}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(busy == 0 && done == 0 && bus_rd == 0 && bus_wr == 0, "R12 outputs after reset",
        {busy, done, bus_rd, bus_wr}, 0);
    mon_en = 1'b1;

    // R1/R3/R4/R6/R7/R8/R9: hardware entry at an instruction end
    run_entry(1'b0, 6'd5, 3'd5, 16'hA5C3, 16'h0800, 20'hA1234, 3'd2, 1'b0, 24'h0ABCDE, 1'b0, 1'b0);
    // R2: suspendable instruction, vector high nibble masked (R8)
    run_entry(1'b0, 6'd31, 3'd7, 16'h3FC2, 16'h1002, 20'h5F0E1, 3'd6, 1'b1, 24'hF7A055, 1'b0, 1'b0);
    // R1: held off until the instruction ends
    run_entry(1'b0, 6'd1, 3'd4, 16'h00C0, 16'h0200, 20'h00010, 3'd0, 1'b0, 24'h012345, 1'b1, 1'b0);
    // R5: software 40 keeps stack select, software 10 clears it; R11 pokes during run
    run_entry(1'b1, 6'd40, 3'd0, 16'hA5C3, 16'h0400, 20'h33333, 3'd3, 1'b0, 24'h0C0001, 1'b0, 1'b1);
    run_entry(1'b1, 6'd10, 3'd0, 16'h0082, 16'h0400, 20'h44444, 3'd3, 1'b0, 24'h022222, 1'b0, 1'b0);
    // R1: software request accepted with interrupts disabled
    run_entry(1'b1, 6'd63, 3'd0, 16'h0080, 16'hFFFE, 20'hFFFFF, 3'd7, 1'b0, 24'h112233, 1'b0, 1'b0);

    // R1: blocked requests
    blocked(16'h0000, 3'd0, 3'd7, "R1 blocked by enable bit");
    blocked(16'h0040, 3'd4, 3'd4, "R1 blocked by equal level");
    chk(bus_rd == 0 && bus_wr == 0, "R10 bus quiet while idle", {bus_rd, bus_wr}, 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #2000000;
    n_chk++; n_err++;
    $display("FAIL watchdog R11 actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule